// File: doc/BRIEF.md
# PLL Bring-up and Retune Sequencer

This block is a hardware sequencer that takes over the control-register writes needed to start a clock-multiplying PLL, change its settings while the chip runs, and turn it off. A controller issues a one-cycle start with an operation code and a set of target settings. The settings are the reference source select, the reference divider, the loop-filter range, the oscillator-current range, the multiplier and the flash read wait-state value. The sequencer then walks a fixed order of writes to the PLL control fields, the flash read-timing field and the system clock select. It waits where the order needs it: on the reference-stable flag, on a settling delay, and on the lock flag.

Changing the flash wait states must never leave the flash too slow for the clock it sees. A direction flag therefore moves that write. When the new frequency is higher, the wait states are raised before the PLL is stopped. When it is lower, they are reduced only after the system clock has returned to the PLL. A retune or a shutdown first parks the system clock on the safe source. A lock that does not arrive within a programmable number of cycles ends the operation with a timeout flag, and the clock stays parked.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, every PLL field, power, enable, the flash timing field and the system clock select are 0 (0 = safe source, 1 = PLL). Busy, done and timeout are also 0.
- R2: A start is taken only while idle and only with op code 0 (bring-up), 1 (retune) or 2 (shutdown). Op code 3, and any start while busy, has no effect. The settings are captured in the cycle the start is taken, so later changes to the setting inputs do not reach the outputs.
- R3: Bring-up holds in a wait until the reference-stable input is high. The source select is written two cycles after the first cycle in which that input is seen high.
- R4: Bring-up writes one field per cycle in this order: source select, flash timing, power on, divider, loop filter, oscillator current, multiplier. Enable is never high while power is low.
- R5: Enable is written exactly SETTLE+1 cycles after the multiplier, where SETTLE = ceil(SETTLE_NS x CLK_KHZ / 10^6), and never sooner.
- R6: After enable, the system clock select goes to 1 only after a 0-to-1 change of the lock input. That change is seen through LOCK_SYNC synchronizer stages, and the select is written LOCK_SYNC+2 cycles after the lock input rises.
- R7: A retune first writes the select to 0, then waits for reference-stable, then writes the new source select.
- R8: In a retune toward a higher frequency (direction input 1), the flash timing field is written in the cycle after the source select and before enable is cleared.
- R9: In a retune toward a lower frequency, the flash timing field is left unchanged until the cycle after the select returns to 1, and is written then.
- R10: A retune clears enable, then rewrites the divider, loop filter, oscillator current and multiplier, one per cycle. It then applies the R5 delay, sets enable, and waits for lock as in R6.
- R11: Shutdown writes the select to 0, then clears enable and power together in the next cycle.
- R12: If no lock rise is seen within L cycles of waiting (L = lock limit input, 0 treated as 1), the timeout flag is set, the select is not changed and the sequencer returns to idle. The flag stays set until the next start is taken.
- R13: Done is high for exactly one cycle at the end of every operation, timeouts included. Busy is high from the cycle after a start is taken through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controlling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command pulse |
| op_i | input | 2 | Operation code: 0 bring-up, 1 retune, 2 shutdown |
| ref_sel_i | input | 1 | Target PLL reference source |
| div_i | input | DIV_W | Target reference divider |
| flt_i | input | FLT_W | Target loop-filter range |
| ico_i | input | ICO_W | Target oscillator-current range |
| mul_i | input | MUL_W | Target multiplier |
| flash_rt_i | input | FLRT_W | Target flash read wait states |
| faster_i | input | 1 | 1 when the new frequency is higher |
| ref_stable_i | input | 1 | Chosen reference is running and stable |
| pll_lock_i | input | 1 | PLL lock indication |
| lock_limit_i | input | TO_W | Lock wait limit in cycles |
| pll_ref_sel_o | output | 1 | PLL reference source field |
| pll_pwr_o | output | 1 | PLL power field |
| pll_en_o | output | 1 | PLL enable field |
| pll_div_o | output | DIV_W | PLL divider field |
| pll_flt_o | output | FLT_W | PLL loop-filter field |
| pll_ico_o | output | ICO_W | PLL oscillator-current field |
| pll_mul_o | output | MUL_W | PLL multiplier field |
| flash_rt_o | output | FLRT_W | Flash read-timing field |
| sys_pll_sel_o | output | 1 | System clock select, 1 = PLL |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Lock wait expired |

## Verification
The assertions assume that the lock input, once high while the PLL is enabled, stays high until enable is cleared. They also assume that a bring-up is never issued while the system clock already runs from the PLL. The stimulus keeps to both: the behavioural PLL in the bench raises lock only after enable has been set, drops it only after enable is cleared, and sends a bring-up only from the reset state or after a shutdown. The bench drives lock and reference-stable synchronously and at known cycles. Its cycle-by-cycle model can therefore place every write, including the extra synchronizer delay on lock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    OP_BRINGUP  = 2'd0,
    OP_RETUNE   = 2'd1,
    OP_SHUTDOWN = 2'd2,
    OP_NONE     = 2'd3
  } op_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PARK,
    ST_WAIT_REF,
    ST_SRC,
    ST_FLASH_PRE,
    ST_PWR_ON,
    ST_DIS,
    ST_DIV,
    ST_FLT,
    ST_ICO,
    ST_MUL,
    ST_SETTLE,
    ST_ENABLE,
    ST_WAIT_LOCK,
    ST_SWITCH,
    ST_FLASH_POST,
    ST_OFF,
    ST_FINISH
  } state_e;

  // Settling delay in controlling-clock cycles, rounded up, at least 1.
  function automatic int unsigned settle_cycles(int unsigned clk_khz, int unsigned wait_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(clk_khz) * longint'(wait_ns);
    cyc  = (prod + 64'd999999) / 64'd1000000;
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W:0]   elapsed;

  // Cycles spent in the current run including this one; limit 0 behaves as 1.
  assign elapsed = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign hit_o   = run_i && (elapsed >= {1'b0, limit_i});

  always_comb begin
    cnt_d = '0;
    if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pll_seq_lock_edge.sv
module pll_seq_lock_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic rise_o
);

  logic lock_s;
  logic lock_prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign lock_s = lock_i;
    end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= lock_i;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign lock_s = sh_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_prev_q <= 1'b0;
    else        lock_prev_q <= lock_s;
  end

  assign rise_o = lock_s & ~lock_prev_q;

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int FLT_W  = 4,
  parameter int ICO_W  = 2,
  parameter int MUL_W  = 8,
  parameter int FLRT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              ref_sel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FLT_W-1:0]  flt_i,
  input  logic [ICO_W-1:0]  ico_i,
  input  logic [MUL_W-1:0]  mul_i,
  input  logic [FLRT_W-1:0] flash_rt_i,
  input  logic              faster_i,
  input  logic              ref_stable_i,
  input  logic              settle_hit_i,
  input  logic              lock_rise_i,
  input  logic              lock_to_hit_i,
  output logic              settle_run_o,
  output logic              lock_run_o,
  output logic              pll_ref_sel_o,
  output logic              pll_pwr_o,
  output logic              pll_en_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic [FLT_W-1:0]  pll_flt_o,
  output logic [ICO_W-1:0]  pll_ico_o,
  output logic [MUL_W-1:0]  pll_mul_o,
  output logic [FLRT_W-1:0] flash_rt_o,
  output logic              sys_pll_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  state_e state_q, state_d;
  logic   accept;

  // Snapshot of the request
  logic [1:0]        op_q;
  logic              fast_q;
  logic              c_src_q;
  logic [DIV_W-1:0]  c_div_q;
  logic [FLT_W-1:0]  c_flt_q;
  logic [ICO_W-1:0]  c_ico_q;
  logic [MUL_W-1:0]  c_mul_q;
  logic [FLRT_W-1:0] c_flrt_q;

  // Control fields driven to the PLL, flash and clock mux
  logic              src_q, pwr_q, en_q, sel_q, to_q;
  logic [DIV_W-1:0]  div_q;
  logic [FLT_W-1:0]  flt_q;
  logic [ICO_W-1:0]  ico_q;
  logic [MUL_W-1:0]  mul_q;
  logic [FLRT_W-1:0] flrt_q;

  // Write enables
  logic wr_src, wr_flash, wr_pwr_on, wr_en_off, wr_div, wr_flt, wr_ico, wr_mul;
  logic wr_en_on, wr_park, wr_switch, wr_off, to_set;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (op_i != OP_NONE)) begin
          accept  = 1'b1;
          state_d = (op_i == OP_BRINGUP) ? ST_WAIT_REF : ST_PARK;
        end
      end
      ST_PARK:       state_d = (op_q == OP_SHUTDOWN) ? ST_OFF : ST_WAIT_REF;
      ST_WAIT_REF:   if (ref_stable_i) state_d = ST_SRC;
      ST_SRC:        state_d = ((op_q == OP_BRINGUP) || fast_q) ? ST_FLASH_PRE : ST_DIS;
      ST_FLASH_PRE:  state_d = (op_q == OP_BRINGUP) ? ST_PWR_ON : ST_DIS;
      ST_PWR_ON:     state_d = ST_DIV;
      ST_DIS:        state_d = ST_DIV;
      ST_DIV:        state_d = ST_FLT;
      ST_FLT:        state_d = ST_ICO;
      ST_ICO:        state_d = ST_MUL;
      ST_MUL:        state_d = ST_SETTLE;
      ST_SETTLE:     if (settle_hit_i) state_d = ST_ENABLE;
      ST_ENABLE:     state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: begin
        if (lock_rise_i)        state_d = ST_SWITCH;
        else if (lock_to_hit_i) state_d = ST_FINISH;
      end
      ST_SWITCH:     state_d = ((op_q == OP_RETUNE) && !fast_q) ? ST_FLASH_POST : ST_FINISH;
      ST_FLASH_POST: state_d = ST_FINISH;
      ST_OFF:        state_d = ST_FINISH;
      ST_FINISH:     state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wr_src    = (state_q == ST_SRC);
    wr_flash  = (state_q == ST_FLASH_PRE) || (state_q == ST_FLASH_POST);
    wr_pwr_on = (state_q == ST_PWR_ON);
    wr_en_off = (state_q == ST_DIS);
    wr_div    = (state_q == ST_DIV);
    wr_flt    = (state_q == ST_FLT);
    wr_ico    = (state_q == ST_ICO);
    wr_mul    = (state_q == ST_MUL);
    wr_en_on  = (state_q == ST_ENABLE);
    wr_park   = (state_q == ST_PARK);
    wr_switch = (state_q == ST_SWITCH);
    wr_off    = (state_q == ST_OFF);
    to_set    = (state_q == ST_WAIT_LOCK) && !lock_rise_i && lock_to_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      fast_q   <= 1'b0;
      c_src_q  <= 1'b0;
      c_div_q  <= '0;
      c_flt_q  <= '0;
      c_ico_q  <= '0;
      c_mul_q  <= '0;
      c_flrt_q <= '0;
      src_q    <= 1'b0;
      pwr_q    <= 1'b0;
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      to_q     <= 1'b0;
      div_q    <= '0;
      flt_q    <= '0;
      ico_q    <= '0;
      mul_q    <= '0;
      flrt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q     <= op_i;
        fast_q   <= faster_i;
        c_src_q  <= ref_sel_i;
        c_div_q  <= div_i;
        c_flt_q  <= flt_i;
        c_ico_q  <= ico_i;
        c_mul_q  <= mul_i;
        c_flrt_q <= flash_rt_i;
      end
      if (wr_src)   src_q  <= c_src_q;
      if (wr_flash) flrt_q <= c_flrt_q;
      if (wr_div)   div_q  <= c_div_q;
      if (wr_flt)   flt_q  <= c_flt_q;
      if (wr_ico)   ico_q  <= c_ico_q;
      if (wr_mul)   mul_q  <= c_mul_q;
      if (wr_pwr_on)   pwr_q <= 1'b1;
      else if (wr_off) pwr_q <= 1'b0;
      if (wr_en_on)                  en_q <= 1'b1;
      else if (wr_en_off || wr_off)  en_q <= 1'b0;
      if (wr_park)        sel_q <= 1'b0;
      else if (wr_switch) sel_q <= 1'b1;
      if (accept)      to_q <= 1'b0;
      else if (to_set) to_q <= 1'b1;
    end
  end

  assign settle_run_o  = (state_q == ST_SETTLE);
  assign lock_run_o    = (state_q == ST_WAIT_LOCK);
  assign pll_ref_sel_o = src_q;
  assign pll_pwr_o     = pwr_q;
  assign pll_en_o      = en_q;
  assign pll_div_o     = div_q;
  assign pll_flt_o     = flt_q;
  assign pll_ico_o     = ico_q;
  assign pll_mul_o     = mul_q;
  assign flash_rt_o    = flrt_q;
  assign sys_pll_sel_o = sel_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FINISH);
  assign timeout_o     = to_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R13
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R13
  AST_EN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en_o |-> pll_pwr_o); // R4
  AST_PARKED_FOR_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_REF && op_q == OP_RETUNE) |-> !sys_pll_sel_o); // R7
  AST_SWITCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_pll_sel_o) |-> pll_en_o); // R6
  AST_TIMEOUT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(timeout_o) && op_q == OP_RETUNE) |-> !sys_pll_sel_o); // R12
  AST_SHUT_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_pwr_o) |-> !pll_en_o); // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> ($stable(pll_div_o) && $stable(pll_mul_o))); // R2

endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int SETTLE_NS = 5000,
  parameter int DIV_W     = 5,
  parameter int FLT_W     = 4,
  parameter int ICO_W     = 2,
  parameter int MUL_W     = 8,
  parameter int FLRT_W    = 2,
  parameter int TO_W      = 16,
  parameter int LOCK_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              ref_sel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FLT_W-1:0]  flt_i,
  input  logic [ICO_W-1:0]  ico_i,
  input  logic [MUL_W-1:0]  mul_i,
  input  logic [FLRT_W-1:0] flash_rt_i,
  input  logic              faster_i,
  input  logic              ref_stable_i,
  input  logic              pll_lock_i,
  input  logic [TO_W-1:0]   lock_limit_i,
  output logic              pll_ref_sel_o,
  output logic              pll_pwr_o,
  output logic              pll_en_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic [FLT_W-1:0]  pll_flt_o,
  output logic [ICO_W-1:0]  pll_ico_o,
  output logic [MUL_W-1:0]  pll_mul_o,
  output logic [FLRT_W-1:0] flash_rt_o,
  output logic              sys_pll_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_KHZ, SETTLE_NS);
  localparam int          SW         = $clog2(SETTLE_CYC + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  logic settle_run, settle_hit, lock_run, lock_to_hit, lock_rise;

  pll_seq_timer #(.W(SW)) u_settle (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (settle_run),
    .limit_i (SW'(SETTLE_CYC)),
    .hit_o   (settle_hit)
  );

  pll_seq_timer #(.W(TO_W)) u_lock_to (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (lock_run),
    .limit_i (lock_limit_i),
    .hit_o   (lock_to_hit)
  );

  pll_seq_lock_edge #(.STAGES(LOCK_SYNC)) u_lock_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lock_i (pll_lock_i),
    .rise_o (lock_rise)
  );

  pll_seq_ctrl #(
    .DIV_W  (DIV_W),
    .FLT_W  (FLT_W),
    .ICO_W  (ICO_W),
    .MUL_W  (MUL_W),
    .FLRT_W (FLRT_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_i       (start_i),
    .op_i          (op_i),
    .ref_sel_i     (ref_sel_i),
    .div_i         (div_i),
    .flt_i         (flt_i),
    .ico_i         (ico_i),
    .mul_i         (mul_i),
    .flash_rt_i    (flash_rt_i),
    .faster_i      (faster_i),
    .ref_stable_i  (ref_stable_i),
    .settle_hit_i  (settle_hit),
    .lock_rise_i   (lock_rise),
    .lock_to_hit_i (lock_to_hit),
    .settle_run_o  (settle_run),
    .lock_run_o    (lock_run),
    .pll_ref_sel_o (pll_ref_sel_o),
    .pll_pwr_o     (pll_pwr_o),
    .pll_en_o      (pll_en_o),
    .pll_div_o     (pll_div_o),
    .pll_flt_o     (pll_flt_o),
    .pll_ico_o     (pll_ico_o),
    .pll_mul_o     (pll_mul_o),
    .flash_rt_o    (flash_rt_o),
    .sys_pll_sel_o (sys_pll_sel_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
  );

  // Enable may only follow the end of a full settling count two cycles earlier.
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pll_en_o) |-> $past(settle_hit, 2)); // R5
  AST_SELECT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sys_pll_sel_o) |-> $past(lock_rise, 2)); // R6

endmodule

// File: tb/pll_seq_top_tb_top.sv
module pll_seq_top_tb_top;

  localparam int CLK_KHZ   = 100000;
  localparam int SETTLE_NS = 5000;
  localparam int DIV_W     = 5;
  localparam int FLT_W     = 4;
  localparam int ICO_W     = 2;
  localparam int MUL_W     = 8;
  localparam int FLRT_W    = 2;
  localparam int TO_W      = 16;
  localparam int LOCK_SYNC = 2;
  localparam longint SETTLE_L = (longint'(SETTLE_NS) * CLK_KHZ + 999999) / 1000000;
  localparam int SETTLE = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
  localparam int VW = 1 + DIV_W + FLT_W + ICO_W + MUL_W + FLRT_W + 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              start_i;
  logic [1:0]        op_i;
  logic              ref_sel_i;
  logic [DIV_W-1:0]  div_i;
  logic [FLT_W-1:0]  flt_i;
  logic [ICO_W-1:0]  ico_i;
  logic [MUL_W-1:0]  mul_i;
  logic [FLRT_W-1:0] flash_rt_i;
  logic              faster_i;
  logic              ref_stable_i;
  logic              pll_lock_i;
  logic [TO_W-1:0]   lock_limit_i;
  logic              pll_ref_sel_o, pll_pwr_o, pll_en_o;
  logic [DIV_W-1:0]  pll_div_o;
  logic [FLT_W-1:0]  pll_flt_o;
  logic [ICO_W-1:0]  pll_ico_o;
  logic [MUL_W-1:0]  pll_mul_o;
  logic [FLRT_W-1:0] flash_rt_o;
  logic              sys_pll_sel_o, busy_o, done_o, timeout_o;

  pll_seq_top #(
    .CLK_KHZ(CLK_KHZ), .SETTLE_NS(SETTLE_NS), .DIV_W(DIV_W), .FLT_W(FLT_W),
    .ICO_W(ICO_W), .MUL_W(MUL_W), .FLRT_W(FLRT_W), .TO_W(TO_W), .LOCK_SYNC(LOCK_SYNC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .ref_sel_i(ref_sel_i),
    .div_i(div_i), .flt_i(flt_i), .ico_i(ico_i), .mul_i(mul_i), .flash_rt_i(flash_rt_i),
    .faster_i(faster_i), .ref_stable_i(ref_stable_i), .pll_lock_i(pll_lock_i),
    .lock_limit_i(lock_limit_i), .pll_ref_sel_o(pll_ref_sel_o), .pll_pwr_o(pll_pwr_o),
    .pll_en_o(pll_en_o), .pll_div_o(pll_div_o), .pll_flt_o(pll_flt_o), .pll_ico_o(pll_ico_o),
    .pll_mul_o(pll_mul_o), .flash_rt_o(flash_rt_o), .sys_pll_sel_o(sys_pll_sel_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  // Reference model state: what each output should hold after the latest edge
  logic              e_src, e_pwr, e_en, e_sel, e_busy, e_done, e_to;
  logic [DIV_W-1:0]  e_div;
  logic [FLT_W-1:0]  e_flt;
  logic [ICO_W-1:0]  e_ico;
  logic [MUL_W-1:0]  e_mul;
  logic [FLRT_W-1:0] e_flrt;

  int    checks = 0;
  int    failures = 0;
  bit    chk_on = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  function automatic logic [VW-1:0] act_vec();
    return {pll_ref_sel_o, pll_div_o, pll_flt_o, pll_ico_o, pll_mul_o, flash_rt_o,
            pll_pwr_o, pll_en_o, sys_pll_sel_o, busy_o, done_o, timeout_o};
  endfunction

  function automatic logic [VW-1:0] exp_vec();
    return {e_src, e_div, e_flt, e_ico, e_mul, e_flrt, e_pwr, e_en, e_sel, e_busy, e_done, e_to};
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s outputs act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare the whole output set with the model every cycle
  always @(negedge clk) begin
    if (chk_on && !finished) check(cur_req, act_vec(), exp_vec());
  end

  task automatic step();
    @(posedge clk);
    #1;
    e_done = 1'b0;
  endtask

  task automatic set_cfg(logic s, logic [DIV_W-1:0] d, logic [FLT_W-1:0] f,
                         logic [ICO_W-1:0] c, logic [MUL_W-1:0] m, logic [FLRT_W-1:0] r);
    ref_sel_i = s; div_i = d; flt_i = f; ico_i = c; mul_i = m; flash_rt_i = r;
  endtask

  task automatic accept_start(logic [1:0] op, logic fast);
    op_i = op; faster_i = fast; start_i = 1'b1;
    step();
    start_i = 1'b0;
    cur_req = "R13";
    e_busy = 1'b1;
    e_to = 1'b0;   // R12: flag cleared when a start is taken
  endtask

  // Divider .. settle .. enable, shared by bring-up and retune
  task automatic write_loop(logic [DIV_W-1:0] d, logic [FLT_W-1:0] f,
                            logic [ICO_W-1:0] c, logic [MUL_W-1:0] m);
    step(); e_div = d;
    step(); e_flt = f;
    step(); e_ico = c;
    step(); e_mul = m;
    cur_req = "R5";
    repeat (SETTLE) step();
    step(); e_en = 1'b1;
  endtask

  // Lock wait; lockdly < 0 means lock never comes
  task automatic lock_phase(int lockdly, int lim, bit post_flash, logic [FLRT_W-1:0] r);
    int eff;
    if (lockdly < 0) begin
      cur_req = "R12";
      eff = (lim == 0) ? 1 : lim;
      repeat (eff - 1) step();
      step(); e_to = 1'b1; e_done = 1'b1;
    end else begin
      cur_req = "R6";
      repeat (lockdly) step();
      pll_lock_i = 1'b1;
      repeat (LOCK_SYNC) step();
      step();
      step(); e_sel = 1'b1;
      if (post_flash) begin
        cur_req = "R9";
        step(); e_flrt = r;
      end
      e_done = 1'b1;
    end
    cur_req = "R13";
    step(); e_busy = 1'b0;
  endtask

  task automatic run_bringup(logic s, logic [DIV_W-1:0] d, logic [FLT_W-1:0] f,
                             logic [ICO_W-1:0] c, logic [MUL_W-1:0] m, logic [FLRT_W-1:0] r,
                             int refdly, int lockdly, bit poke);
    set_cfg(s, d, f, c, m, r);
    ref_stable_i = (refdly == 0);
    accept_start(2'd0, 1'b0);
    cur_req = (poke) ? "R2" : "R3";
    if (poke) begin
      // settings changed and a new start issued while busy: both ignored
      set_cfg(~s, ~d, ~f, ~c, ~m, ~r);
      op_i = 2'd2; start_i = 1'b1;
    end
    repeat (refdly) step();
    start_i = 1'b0;
    ref_stable_i = 1'b1;
    step();
    cur_req = "R4";
    step(); e_src = s;
    step(); e_flrt = r;
    step(); e_pwr = 1'b1;
    write_loop(d, f, c, m);
    lock_phase(lockdly, int'(lock_limit_i), 1'b0, r);
  endtask

  task automatic run_retune(logic fast, logic s, logic [DIV_W-1:0] d, logic [FLT_W-1:0] f,
                            logic [ICO_W-1:0] c, logic [MUL_W-1:0] m, logic [FLRT_W-1:0] r,
                            int refdly, int lockdly);
    set_cfg(s, d, f, c, m, r);
    ref_stable_i = (refdly == 0);
    accept_start(2'd1, fast);
    cur_req = "R7";
    step(); e_sel = 1'b0;
    repeat (refdly) step();
    ref_stable_i = 1'b1;
    step();
    step(); e_src = s;
    if (fast) begin
      cur_req = "R8";
      step(); e_flrt = r;
    end
    cur_req = "R10";
    step(); e_en = 1'b0;
    pll_lock_i = 1'b0;
    write_loop(d, f, c, m);
    lock_phase(lockdly, int'(lock_limit_i), !fast, r);
  endtask

  task automatic run_shutdown();
    accept_start(2'd2, 1'b0);
    cur_req = "R11";
    step(); e_sel = 1'b0;
    step(); e_en = 1'b0; e_pwr = 1'b0; e_done = 1'b1;
    pll_lock_i = 1'b0;
    cur_req = "R13";
    step(); e_busy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'd0; faster_i = 1'b0;
    ref_stable_i = 1'b0; pll_lock_i = 1'b0; lock_limit_i = TO_W'(64);
    set_cfg(1'b0, '0, '0, '0, '0, '0);
    e_src = 1'b0; e_pwr = 1'b0; e_en = 1'b0; e_sel = 1'b0; e_busy = 1'b0;
    e_done = 1'b0; e_to = 1'b0; e_div = '0; e_flt = '0; e_ico = '0; e_mul = '0; e_flrt = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    cur_req = "R1";
    chk_on = 1'b1;
    step();
    check("R1", act_vec(), {VW{1'b0}});

    // R2: op code 3 is not taken
    cur_req = "R2";
    op_i = 2'd3; start_i = 1'b1;
    repeat (3) step();
    start_i = 1'b0;
    step();

    run_bringup(1'b1, 5'd3, 4'h9, 2'd2, 8'd40, 2'd1, 3, 4, 1'b1);
    run_retune(1'b1, 1'b0, 5'd7, 4'h5, 2'd3, 8'd90, 2'd3, 2, 1);
    run_retune(1'b0, 1'b1, 5'd1, 4'hc, 2'd1, 8'd12, 2'd0, 0, 3);

    // R12: lock never arrives, then limit 0 acts as a single cycle
    lock_limit_i = TO_W'(10);
    run_retune(1'b0, 1'b0, 5'd9, 4'h2, 2'd0, 8'd77, 2'd2, 1, -1);
    lock_limit_i = '0;
    run_retune(1'b1, 1'b1, 5'd4, 4'h3, 2'd1, 8'd55, 2'd3, 0, -1);
    lock_limit_i = TO_W'(64);
    run_retune(1'b0, 1'b1, 5'd30, 4'hf, 2'd3, 8'd200, 2'd1, 1, 2);

    run_shutdown();
    step();
    run_bringup(1'b0, 5'd17, 4'h1, 2'd0, 8'd255, 2'd2, 0, 0, 1'b0);
    repeat (3) step();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL %s watchdog expired act=running exp=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule